// File: doc/BRIEF.md
# Memory-to-Memory Copy Engine

This block moves a block of words from one place in memory to another without the processor executing loads and stores. Software fills in a source address, a destination address and a length in bytes through a small register window, then sets the start bit. The engine takes the memory bus as master and handles one word at a time. It reads a word from the current source address, then writes that word to the current destination address. Both pointers then advance by one word.

While a copy runs, software can watch a live count of the bytes already written. When the last word has been written, a sticky completion flag is raised. If interrupts are enabled, a level interrupt is also raised. Software clears the flag by writing a one to it. The memory side uses a valid/ready request handshake and a separate read-data valid strobe, so memories of any latency can be attached.

Top module: `dma_copy_engine`

## Requirements
- R1: After reset, all six registers read 0, the interrupt is low and no master request is raised.
- R2: Registers are selected by byte offset: source address 0x00, destination address 0x04, length 0x08, control 0x0C, status 0x10, progress 0x14. In the address and length registers, the two lowest bits and any bits above the configured width read back as 0.
- R3: Writing control with bit 0 (start) set begins a copy only when the engine is idle and the stored length is non-zero; otherwise the start is ignored. Bit 0 always reads back as 0, and bit 1 (interrupt enable) reads back as written.
- R4: A copy of length L performs L/4 word moves. Each move is a read from the current source address followed by a write of the returned data to the current destination address. Both addresses rise by 4 after each accepted write, and the next read is only issued after the previous write has been accepted.
- R5: Status bit 0 (busy) is 1 from the cycle after an accepted start until the cycle after the last write is accepted.
- R6: The progress register reads 0 right after a start, rises by 4 with each accepted write, never decreases during a copy, and equals L when the copy ends.
- R7: Status bit 1 (done) is set when a copy completes and cleared when a new copy starts. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R8: The interrupt output is high exactly when done is set and interrupt enable is 1.
- R9: Writing the address or length registers during a copy updates their read-back values but does not change the copy in flight.
- R10: A master request not yet accepted keeps its valid, direction, address and write data unchanged until ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wen | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| m_req_valid | output | 1 | Master request valid |
| m_req_ready | input | 1 | Master request accepted |
| m_req_write | output | 1 | 1 = write request, 0 = read request |
| m_req_addr | output | ADDR_W | Master byte address |
| m_req_wdata | output | DATA_W | Master write data |
| m_rdata_valid | input | 1 | Read data strobe |
| m_rdata | input | DATA_W | Read data |
| irq | output | 1 | Completion interrupt level |

## Verification
The bench builds the engine with a 12-bit address (ADDR_W=12), a 10-bit length (LEN_W=10) and 32-bit words. This lets a 1024-word memory model cover the whole address space. It also brings the largest legal copy, 255 words (0x3FC bytes), into a short run. With these narrow widths, the clipping of high bits in the address and length registers shows up directly on read-back. The memory model randomises request acceptance and read latency, so every handshake state of the copy loop is exercised.

// File: rtl/dma_copy_pkg.sv
// Package: shared constants and types for the copy engine.
// Assumes a 32-bit register window selected by byte offset.
package dma_copy_pkg;
    localparam int REG_W  = 32;
    localparam int CFG_AW = 5;

    // Word index of each register (byte offset / 4)
    localparam logic [2:0] IDX_SRC  = 3'd0;
    localparam logic [2:0] IDX_DST  = 3'd1;
    localparam logic [2:0] IDX_LEN  = 3'd2;
    localparam logic [2:0] IDX_CTRL = 3'd3;
    localparam logic [2:0] IDX_STAT = 3'd4;
    localparam logic [2:0] IDX_PROG = 3'd5;

    localparam int BIT_START = 0;
    localparam int BIT_IRQEN = 1;
    localparam int BIT_BUSY  = 0;
    localparam int BIT_DONE  = 1;

    typedef enum logic [1:0] {
        MV_IDLE,
        MV_RD_REQ,
        MV_RD_WAIT,
        MV_WR_REQ
    } mv_state_t;
endpackage

// File: rtl/dma_copy_regs.sv
// Register window of the copy engine: address/length storage, control,
// sticky completion flag with write-one-to-clear, and read-back mux.
// Assumes one register write per cycle and combinational read data.
module dma_copy_regs
    import dma_copy_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wen,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              busy,
    input  logic [LEN_W-1:0]  bytes_done,
    input  logic              xfer_done,
    output logic [ADDR_W-1:0] src_base,
    output logic [ADDR_W-1:0] dst_base,
    output logic [LEN_W-1:0]  len_bytes,
    output logic              start_go,
    output logic              irq_en,
    output logic              done_flag
);
    localparam int STEP = DATA_W / 8;
    localparam logic [ADDR_W-1:0] A_MASK = ~ADDR_W'(STEP - 1);
    localparam logic [LEN_W-1:0]  L_MASK = ~LEN_W'(STEP - 1);

    logic [2:0] idx;
    logic       wr_src, wr_dst, wr_len, wr_ctrl, wr_stat;
    logic       unused_bits;

    assign idx         = cfg_addr[CFG_AW-1:2];
    assign unused_bits = ^{cfg_addr[1:0], cfg_wdata};

    // Decode register writes by word index
    always_comb begin
        wr_src  = cfg_wen && (idx == IDX_SRC);
        wr_dst  = cfg_wen && (idx == IDX_DST);
        wr_len  = cfg_wen && (idx == IDX_LEN);
        wr_ctrl = cfg_wen && (idx == IDX_CTRL);
        wr_stat = cfg_wen && (idx == IDX_STAT);
    end

    // Accept start only when idle and length is non-zero
    assign start_go = wr_ctrl && cfg_wdata[BIT_START] && !busy && (len_bytes != '0);

    // Store addresses, length and interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_base  <= '0;
            dst_base  <= '0;
            len_bytes <= '0;
            irq_en    <= 1'b0;
        end else begin
            if (wr_src)  src_base  <= cfg_wdata[ADDR_W-1:0] & A_MASK;
            if (wr_dst)  dst_base  <= cfg_wdata[ADDR_W-1:0] & A_MASK;
            if (wr_len)  len_bytes <= cfg_wdata[LEN_W-1:0] & L_MASK;
            if (wr_ctrl) irq_en    <= cfg_wdata[BIT_IRQEN];
        end
    end

    // Sticky completion flag: set wins, cleared by start or a written one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
        end else if (xfer_done) begin
            done_flag <= 1'b1;
        end else if (start_go || (wr_stat && cfg_wdata[BIT_DONE])) begin
            done_flag <= 1'b0;
        end
    end

    // Read-back multiplexer, zero-extended to the register width
    always_comb begin
        cfg_rdata = '0;
        case (idx)
            IDX_SRC:  cfg_rdata[ADDR_W-1:0] = src_base;
            IDX_DST:  cfg_rdata[ADDR_W-1:0] = dst_base;
            IDX_LEN:  cfg_rdata[LEN_W-1:0]  = len_bytes;
            IDX_CTRL: cfg_rdata[BIT_IRQEN]  = irq_en;
            IDX_STAT: begin
                cfg_rdata[BIT_BUSY] = busy;
                cfg_rdata[BIT_DONE] = done_flag;
            end
            IDX_PROG: cfg_rdata[LEN_W-1:0]  = bytes_done;
            default:  cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_copy_mover.sv
// Copy state machine: for each word, one master read then one master
// write, with private copies of the pointers and length latched at start.
// Assumes the memory returns exactly one data strobe per accepted read.
module dma_copy_mover
    import dma_copy_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_go,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [LEN_W-1:0]  len_bytes,
    output logic              m_req_valid,
    input  logic              m_req_ready,
    output logic              m_req_write,
    output logic [ADDR_W-1:0] m_req_addr,
    output logic [DATA_W-1:0] m_req_wdata,
    input  logic              m_rdata_valid,
    input  logic [DATA_W-1:0] m_rdata,
    output logic              busy,
    output logic [LEN_W-1:0]  bytes_done,
    output logic              xfer_done
);
    localparam int STEP = DATA_W / 8;

    mv_state_t         state_q;
    logic [ADDR_W-1:0] rd_ptr_q, wr_ptr_q;
    logic [LEN_W-1:0]  len_q, count_q;
    logic [DATA_W-1:0] hold_q;
    logic              wr_fire, last_word;

    assign wr_fire   = (state_q == MV_WR_REQ) && m_req_ready;
    assign last_word = (count_q + LEN_W'(STEP)) == len_q;
    assign xfer_done = wr_fire && last_word;
    assign busy      = (state_q != MV_IDLE);
    assign bytes_done = count_q;

    // Drive the master request from the current state
    always_comb begin
        m_req_valid = (state_q == MV_RD_REQ) || (state_q == MV_WR_REQ);
        m_req_write = (state_q == MV_WR_REQ);
        m_req_addr  = m_req_write ? wr_ptr_q : rd_ptr_q;
        m_req_wdata = hold_q;
    end

    // Sequence read, data capture and write for each word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= MV_IDLE;
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            len_q    <= '0;
            count_q  <= '0;
            hold_q   <= '0;
        end else begin
            case (state_q)
                MV_IDLE: begin
                    if (start_go) begin
                        rd_ptr_q <= src_base;
                        wr_ptr_q <= dst_base;
                        len_q    <= len_bytes;
                        count_q  <= '0;
                        state_q  <= MV_RD_REQ;
                    end
                end
                MV_RD_REQ: begin
                    if (m_req_ready) state_q <= MV_RD_WAIT;
                end
                MV_RD_WAIT: begin
                    if (m_rdata_valid) begin
                        hold_q  <= m_rdata;
                        state_q <= MV_WR_REQ;
                    end
                end
                MV_WR_REQ: begin
                    if (m_req_ready) begin
                        rd_ptr_q <= rd_ptr_q + ADDR_W'(STEP);
                        wr_ptr_q <= wr_ptr_q + ADDR_W'(STEP);
                        count_q  <= count_q + LEN_W'(STEP);
                        state_q  <= last_word ? MV_IDLE : MV_RD_REQ;
                    end
                end
                default: state_q <= MV_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_copy_engine.sv
// Top level of the copy engine: joins the register window and the copy
// state machine and forms the interrupt level.
// Assumes ADDR_W and LEN_W do not exceed the 32-bit register width.
module dma_copy_engine
    import dma_copy_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wen,
    input  logic [4:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              m_req_valid,
    input  logic              m_req_ready,
    output logic              m_req_write,
    output logic [ADDR_W-1:0] m_req_addr,
    output logic [DATA_W-1:0] m_req_wdata,
    input  logic              m_rdata_valid,
    input  logic [DATA_W-1:0] m_rdata,
    output logic              irq
);
    logic [ADDR_W-1:0] src_base, dst_base;
    logic [LEN_W-1:0]  len_bytes, bytes_done;
    logic              start_go, irq_en, done_flag, busy, xfer_done;

    dma_copy_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wen    (cfg_wen),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .busy       (busy),
        .bytes_done (bytes_done),
        .xfer_done  (xfer_done),
        .src_base   (src_base),
        .dst_base   (dst_base),
        .len_bytes  (len_bytes),
        .start_go   (start_go),
        .irq_en     (irq_en),
        .done_flag  (done_flag)
    );

    dma_copy_mover #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_mover (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_go      (start_go),
        .src_base      (src_base),
        .dst_base      (dst_base),
        .len_bytes     (len_bytes),
        .m_req_valid   (m_req_valid),
        .m_req_ready   (m_req_ready),
        .m_req_write   (m_req_write),
        .m_req_addr    (m_req_addr),
        .m_req_wdata   (m_req_wdata),
        .m_rdata_valid (m_rdata_valid),
        .m_rdata       (m_rdata),
        .busy          (busy),
        .bytes_done    (bytes_done),
        .xfer_done     (xfer_done)
    );

    // Interrupt level follows the sticky flag, gated by the enable
    assign irq = done_flag & irq_en;
endmodule

// File: rtl/dma_copy_engine_chk.sv
// Checker for the copy engine: temporal properties on the master port,
// the busy/done relation and progress steps. Bound to every instance.
module dma_copy_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m_req_valid,
    input logic              m_req_ready,
    input logic              m_req_write,
    input logic [ADDR_W-1:0] m_req_addr,
    input logic [DATA_W-1:0] m_req_wdata,
    input logic              irq,
    input logic              busy,
    input logic              done_flag,
    input logic [LEN_W-1:0]  bytes_done
);
    localparam int STEP = DATA_W / 8;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_req_valid && !m_req_ready |=> m_req_valid && $stable(m_req_addr)
            && $stable(m_req_write) && $stable(m_req_wdata));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !m_req_valid);

    // R5
    busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_flag);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_flag |-> !busy);

    // R6
    progress_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> (bytes_done == $past(bytes_done))
            || (bytes_done == $past(bytes_done) + LEN_W'(STEP)));

    // R8
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy);

    // R4
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_req_valid |-> (m_req_addr & ADDR_W'(STEP - 1)) == '0);
endmodule

bind dma_copy_engine dma_copy_engine_chk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .m_req_valid (m_req_valid),
    .m_req_ready (m_req_ready),
    .m_req_write (m_req_write),
    .m_req_addr  (m_req_addr),
    .m_req_wdata (m_req_wdata),
    .irq         (irq),
    .busy        (busy),
    .done_flag   (done_flag),
    .bytes_done  (bytes_done)
);

// File: tb/dma_copy_engine_tb.sv
`timescale 1ns/1ps
module dma_copy_engine_tb;
    localparam int ADDR_W = 12;
    localparam int LEN_W  = 10;
    localparam int DATA_W = 32;
    localparam int WORDS  = 1 << (ADDR_W - 2);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wen = 1'b0;
    logic [4:0]        cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic              m_req_valid, m_req_write;
    logic              m_req_ready = 1'b0;
    logic [ADDR_W-1:0] m_req_addr;
    logic [DATA_W-1:0] m_req_wdata;
    logic              m_rdata_valid = 1'b0;
    logic [DATA_W-1:0] m_rdata = '0;
    logic              irq;

    int tests = 0;
    int fails = 0;

    logic [31:0] mem [WORDS];
    logic [ADDR_W-1:0] exp_rd_addr, exp_wr_addr;
    logic [31:0] last_rd_data;
    bit   want_write = 1'b0;
    int   words_written = 0;

    always #10 clk = ~clk;

    dma_copy_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wen(cfg_wen), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .m_req_valid(m_req_valid),
        .m_req_ready(m_req_ready), .m_req_write(m_req_write), .m_req_addr(m_req_addr),
        .m_req_wdata(m_req_wdata), .m_rdata_valid(m_rdata_valid), .m_rdata(m_rdata),
        .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_wen = 1'b1;
        @(negedge clk);
        cfg_wen = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // Memory model: random acceptance and read latency, checks request order
    initial begin
        bit   rd_pend = 1'b0;
        int   rd_dly = 0;
        logic [ADDR_W-3:0] rd_idx = '0;
        bit   stall = 1'b0;
        logic [ADDR_W-1:0] st_addr = '0;
        logic st_wr = 1'b0;
        forever begin
            @(negedge clk);
            m_rdata_valid = 1'b0;
            if (rd_pend) begin
                if (rd_dly == 0) begin
                    m_rdata_valid = 1'b1;
                    m_rdata = mem[rd_idx];
                    rd_pend = 1'b0;
                end else rd_dly--;
            end
            if (stall) // R10: stalled request unchanged
                check(m_req_valid && m_req_addr == st_addr && m_req_write == st_wr,
                      "R10 held request", 32'(m_req_addr), 32'(st_addr));
            m_req_ready = rst_n && (($urandom % 3) != 0);
            if (m_req_valid && m_req_ready) begin
                if (m_req_write) begin
                    check(want_write && m_req_addr == exp_wr_addr && m_req_wdata == last_rd_data,
                          "R4 write order/addr/data", 32'(m_req_addr), 32'(exp_wr_addr));
                    mem[m_req_addr[ADDR_W-1:2]] = m_req_wdata;
                    exp_wr_addr += 4;
                    want_write = 1'b0;
                    words_written++;
                end else begin
                    check(!want_write && m_req_addr == exp_rd_addr,
                          "R4 read order/addr", 32'(m_req_addr), 32'(exp_rd_addr));
                    rd_idx = m_req_addr[ADDR_W-1:2];
                    last_rd_data = mem[rd_idx];
                    rd_pend = 1'b1;
                    rd_dly = $urandom % 3;
                    exp_rd_addr += 4;
                    want_write = 1'b1;
                end
            end
            stall = m_req_valid && !m_req_ready;
            st_addr = m_req_addr;
            st_wr = m_req_write;
        end
    end

    task automatic run_copy(input int src_w, input int dst_w, input int n, input bit ien, input bit poke);
        logic [31:0] v, prev;
        exp_rd_addr = ADDR_W'(src_w * 4);
        exp_wr_addr = ADDR_W'(dst_w * 4);
        want_write = 1'b0;
        words_written = 0;
        reg_write(5'h00, 32'(src_w * 4));
        reg_write(5'h04, 32'(dst_w * 4));
        reg_write(5'h08, 32'(n * 4));
        reg_write(5'h0C, {30'd0, ien, 1'b1});
        reg_read(5'h10, v);
        check(v == 32'h1, "R3 R5 R7 status after start", v, 32'h1);
        reg_read(5'h14, v);
        check(v == 0, "R6 progress at start", v, 0);
        reg_read(5'h0C, v);
        check(v == {30'd0, ien, 1'b0}, "R3 control read-back", v, {30'd0, ien, 1'b0});
        prev = 0;
        for (int k = 0; k < 5000; k++) begin
            reg_read(5'h10, v);
            if (!v[0]) break;
            reg_read(5'h14, v);
            check(v >= prev && v[1:0] == 0 && v <= 32'(n * 4), "R6 progress monotonic", v, prev);
            prev = v;
            if (poke && k == 2) begin // R9 and R3: rewrite and restart while busy
                reg_write(5'h00, 32'h0);
                reg_write(5'h08, 32'h4);
                reg_write(5'h0C, {30'd0, ien, 1'b1});
            end
        end
        check(words_written == n, "R4 word count", 32'(words_written), 32'(n));
        reg_read(5'h14, v);
        check(v == 32'(n * 4), "R6 final progress", v, 32'(n * 4));
        reg_read(5'h10, v);
        check(v == 32'h2, "R5 R7 status at end", v, 32'h2);
        check(irq == ien, "R8 irq level", 32'(irq), 32'(ien));
        for (int i = 0; i < n; i++)
            check(mem[dst_w + i] == mem[src_w + i], "R4 copied data", mem[dst_w + i], mem[src_w + i]);
        if (poke) begin
            reg_read(5'h08, v);
            check(v == 32'h4, "R9 length read-back", v, 32'h4);
            reg_read(5'h00, v);
            check(v == 32'h0, "R9 source read-back", v, 32'h0);
        end
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        for (int i = 0; i < WORDS; i++) mem[i] = $urandom;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            reg_read(5'(a * 4), v);
            check(v == 0, "R1 register reset", v, 0);
        end
        check(!irq && !m_req_valid, "R1 outputs idle", {30'd0, irq, m_req_valid}, 0);

        // R2: masking of low and high bits
        reg_write(5'h00, 32'hFFFF_FFFF);
        reg_read(5'h00, v);
        check(v == 32'hFFC, "R2 source mask", v, 32'hFFC);
        reg_write(5'h04, 32'h0000_0123);
        reg_read(5'h04, v);
        check(v == 32'h120, "R2 destination mask", v, 32'h120);
        reg_write(5'h08, 32'hFFFF_FFFF);
        reg_read(5'h08, v);
        check(v == 32'h3FC, "R2 length mask", v, 32'h3FC);

        // R3: zero length (and length truncating to zero) rejects start
        reg_write(5'h08, 32'h0);
        reg_write(5'h0C, 32'h1);
        reg_read(5'h10, v);
        check(v == 0, "R3 start ignored at length 0", v, 0);
        reg_write(5'h08, 32'h2);
        reg_write(5'h0C, 32'h1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(!m_req_valid, "R3 no request after ignored start", 32'(m_req_valid), 0);
        end

        // Directed: single word, then long copy with interrupt and busy rewrites
        run_copy(10, 600, 1, 1'b0, 1'b0);
        run_copy(0, 512, 64, 1'b1, 1'b1);

        // R7/R8: writing 0 keeps DONE, writing 1 clears it
        reg_write(5'h10, 32'h1);
        reg_read(5'h10, v);
        check(v == 32'h2, "R7 write zero keeps done", v, 32'h2);
        check(irq == 1'b1, "R8 irq stays", 32'(irq), 1);
        reg_write(5'h10, 32'h2);
        reg_read(5'h10, v);
        check(v == 32'h0, "R7 write one clears done", v, 0);
        check(irq == 1'b0, "R8 irq drops", 32'(irq), 0);

        // Largest length the configured width allows
        run_copy(0, 512, 255, 1'b0, 1'b0);

        // Random copies; each start also clears the previous DONE (R7)
        for (int t = 0; t < 8; t++) begin
            int n, s, d;
            n = 1 + ($urandom % 64);
            s = $urandom % (512 - n);
            d = 512 + ($urandom % (512 - n));
            run_copy(s, d, n, 1'($urandom % 2), 1'b0);
        end

        summary();
        $finish;
    end
endmodule